// File: doc/BRIEF.md
# Half-Duplex Serial Transmitter with Line-Driver Enable

This block sends bytes as asynchronous serial frames and controls the enable pin of an external half-duplex line transceiver. A byte written through the write strobe goes into a single holding register. If the transmitter is idle, the driver enable turns on first. After a settling interval of one to two bit times, the frame begins. The frame is made of a low start bit, the data bits sent least significant bit first, an optional parity bit, and one or two high stop bits. All timing is counted in pulses of `baud_tick`, which comes from an external divider and fires once per bit time.

The holding register empties when the start bit has finished. Software then has most of a character time to write the next byte. A byte that is waiting when the last stop bit ends starts at once, and the driver enable stays on between the two frames. When nothing is waiting, the driver enable stays on for one more system clock after the last stop bit and then turns off. The enable pin can be active-high or active-low. An interrupt level shows that the holding register is empty.

Top module: `uart_de_tx`

## Requirements
- R1: A frame is one low start bit, then DATA_W data bits with the least significant bit first, then an optional parity bit, then stop bits at logic 1. Each bit lasts exactly one `baud_tick` period, and `txd` changes only on a clock edge where `baud_tick` was high. The line is 1 when idle.
- R2: When `par_en`=1, a parity bit follows the data. With `par_odd`=0 it makes the total count of ones in data plus parity even; with `par_odd`=1 it makes that count odd. When `two_stop`=1 there are two stop bits, otherwise one.
- R3: When a frame starts from idle, the driver enable becomes active at least one and at most two bit periods before `txd` falls for the start bit.
- R4: When no byte is waiting, the driver enable becomes inactive exactly one system clock after the last stop bit period ends.
- R5: When a byte is waiting as the last stop bit ends, its start bit begins on the same edge and the driver enable stays active without a gap.
- R6: `de_act_low`=0 makes `de` high when active and low when inactive. `de_act_low`=1 inverts `de`.
- R7: A write clears `tdr_empty` on the next clock. `tdr_empty` returns to 1 exactly one bit period after the start bit begins, which is the moment the byte moves into the shifter. Reset leaves `tdr_empty`=1.
- R8: `tx_irq` is 1 exactly when `tdr_empty`=1 and `tx_en`=1.
- R9: A write while `tdr_empty`=0 and before the byte moves into the shifter replaces the waiting byte. Only the newer byte is sent, and nothing reports the replacement.
- R10: While `tx_en`=0 or reset is active, `txd` is 1 and the driver enable is inactive. Any frame in progress is dropped. A byte already waiting stays and is sent after `tx_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enable |
| baud_tick | input | 1 | One-clock pulse per bit period from the external divider |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to send |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| two_stop | input | 1 | 0 one stop bit, 1 two stop bits |
| de_act_low | input | 1 | Driver enable polarity: 1 active-low |
| txd | output | 1 | Serial line |
| de | output | 1 | Transceiver driver enable |
| tdr_empty | output | 1 | Holding register can accept a byte |
| tx_irq | output | 1 | Transmitter interrupt level |

## Verification
A wrong bit counter or a wrong state decode shows up as a frame that is too long or too short. That is visible at the first misplaced mid-bit sample of `txd`, or as the driver-enable fall moving away from N bit periods plus one clock after the start edge. A holding flag that is handled wrong shows up one bit period into the frame, because `tdr_empty` rises early or late. When back-to-back bytes are written, the same fault appears as a missing or doubled frame, or as a gap in `de`. A fault in the lead counting changes the interval from `de` to the start bit within a single frame.

// File: rtl/uart_de_pkg.sv
package uart_de_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_TAIL
  } tx_state_e;

  // Number of stop bits chosen by the stop-count control.
  function automatic int unsigned stop_bits(input logic two);
    return two ? 2 : 1;
  endfunction

  // Parity bit that makes the ones count even (odd=0) or odd (odd=1).
  function automatic logic frame_parity(input logic [63:0] v, input logic odd);
    return (^v) ^ odd;
  endfunction

  // Bits in one frame, start to last stop.
  function automatic int unsigned frame_bits(input int unsigned dw, input logic pen,
                                             input logic two);
    return 1 + dw + (pen ? 1 : 0) + stop_bits(two);
  endfunction

endpackage

// File: rtl/uart_de_holdreg.sv
module uart_de_holdreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load_evt,
  output logic [DATA_W-1:0] tdr_o,
  output logic              empty_o
);

  logic [DATA_W-1:0] tdr_q;
  logic              full_q;

  // A write wins over a transfer on the same edge: the shifter takes the old
  // byte and the new one stays pending.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdr_q  <= '0;
      full_q <= 1'b0;
    end else if (wr_stb) begin
      tdr_q  <= wr_data;
      full_q <= 1'b1;
    end else if (load_evt) begin
      full_q <= 1'b0;
    end
  end

  assign tdr_o   = tdr_q;
  assign empty_o = !full_q;

  a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !empty_o);

  a_r7_empty_rise_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(empty_o) |-> $past(load_evt));

endmodule

// File: rtl/uart_de_seq.sv
module uart_de_seq
  import uart_de_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int LEAD_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              baud_tick,
  input  logic              pending,
  input  logic [DATA_W-1:0] tdr_data,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  output logic              load_evt,
  output logic              frame_end_evt,
  output logic              txd_o,
  output logic              de_on
);

  localparam int CW = $clog2(DATA_W + LEAD_TICKS + 2);

  tx_state_e         state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              par_q, par_d;
  logic              step;
  logic              last_lead, last_data, last_stop;

  assign step      = tx_en && baud_tick;
  assign last_lead = (cnt_q == CW'(LEAD_TICKS - 1));
  assign last_data = (cnt_q == CW'(DATA_W - 1));
  assign last_stop = (cnt_q == CW'(stop_bits(two_stop) - 1));

  assign load_evt      = step && (state_q == ST_START);
  assign frame_end_evt = step && (state_q == ST_STOP) && last_stop;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    par_d   = par_q;
    if (!tx_en) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (pending) begin
            state_d = ST_LEAD;
            cnt_d   = '0;
          end
        end
        ST_LEAD: begin
          if (baud_tick) begin
            if (last_lead) begin
              state_d = ST_START;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_START: begin
          if (baud_tick) begin
            state_d = ST_DATA;
            cnt_d   = '0;
            sh_d    = tdr_data;
            par_d   = frame_parity(64'(tdr_data), par_odd);
          end
        end
        ST_DATA: begin
          if (baud_tick) begin
            sh_d = sh_q >> 1;
            if (last_data) begin
              state_d = par_en ? ST_PAR : ST_STOP;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_PAR: begin
          if (baud_tick) begin
            state_d = ST_STOP;
            cnt_d   = '0;
          end
        end
        ST_STOP: begin
          if (baud_tick) begin
            if (last_stop) begin
              state_d = pending ? ST_START : ST_TAIL;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_TAIL: begin
          state_d = pending ? ST_LEAD : ST_IDLE;
          cnt_d   = '0;
        end
        default: begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      par_q   <= par_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: txd_o = 1'b0;
      ST_DATA:  txd_o = sh_q[0];
      ST_PAR:   txd_o = par_q;
      default:  txd_o = 1'b1;
    endcase
  end

  assign de_on = (state_q != ST_IDLE);

  a_r1_line_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txd_o) |-> $past(baud_tick));

  a_r4_de_drop_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(de_on) |-> ($past(frame_end_evt, 2) || !$past(tx_en)));

  a_r5_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_evt && pending) |=> (de_on && !txd_o));

  a_r10_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (txd_o && !de_on));

endmodule

// File: rtl/uart_de_pins.sv
module uart_de_pins (
  input  logic de_on,
  input  logic de_act_low,
  input  logic empty,
  input  logic tx_en,
  output logic de_o,
  output logic irq_o
);

  assign de_o  = de_on ^ de_act_low;
  assign irq_o = empty && tx_en;

endmodule

// File: rtl/uart_de_tx.sv
module uart_de_tx #(
  parameter int DATA_W     = 8,
  parameter int LEAD_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              baud_tick,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  input  logic              de_act_low,
  output logic              txd,
  output logic              de,
  output logic              tdr_empty,
  output logic              tx_irq
);

  logic [DATA_W-1:0] tdr_data;
  logic              load_evt;
  logic              frame_end_evt;
  logic              de_on;

  uart_de_holdreg #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .load_evt (load_evt),
    .tdr_o    (tdr_data),
    .empty_o  (tdr_empty)
  );

  uart_de_seq #(.DATA_W(DATA_W), .LEAD_TICKS(LEAD_TICKS)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_en         (tx_en),
    .baud_tick     (baud_tick),
    .pending       (!tdr_empty),
    .tdr_data      (tdr_data),
    .par_en        (par_en),
    .par_odd       (par_odd),
    .two_stop      (two_stop),
    .load_evt      (load_evt),
    .frame_end_evt (frame_end_evt),
    .txd_o         (txd),
    .de_on         (de_on)
  );

  uart_de_pins u_pins (
    .de_on      (de_on),
    .de_act_low (de_act_low),
    .empty      (tdr_empty),
    .tx_en      (tx_en),
    .de_o       (de),
    .irq_o      (tx_irq)
  );

  a_r8_irq_drops_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !tx_irq);

endmodule

// File: tb/uart_de_tx_bench.sv
module uart_de_tx_bench;
  localparam int P = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b1;
  logic baud_tick = 1'b0;
  logic wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0, de_low = 1'b0;
  logic txd, de, tdr_empty, tx_irq;

  always #5 clk = ~clk;

  int tcnt = 0;
  always @(posedge clk) begin
    if (tcnt == P - 1) begin tcnt <= 0; baud_tick <= 1'b1; end
    else begin tcnt <= tcnt + 1; baud_tick <= 1'b0; end
  end

  uart_de_tx u_uart_de_tx (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .baud_tick(baud_tick),
    .wr_stb(wr_stb), .wr_data(wr_data), .par_en(par_en), .par_odd(par_odd),
    .two_stop(two_stop), .de_act_low(de_low), .txd(txd), .de(de),
    .tdr_empty(tdr_empty), .tx_irq(tx_irq)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit ln[0:2047], dn[0:2047], em[0:2047], iq[0:2047], rd[0:2047];
  int ns;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nbits();
    return 10 + int'(par_en) + int'(two_stop);
  endfunction

  function automatic bit exp_bit(input logic [7:0] d, input int i);
    if (i == 0) return 1'b0;
    if (i <= 8) return d[i-1];
    if (par_en && i == 9) return (^d) ^ par_odd;
    return 1'b1;
  endfunction

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_data = d; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  // Records one activity burst until the driver enable drops.
  task automatic capture(input bit b2b, input logic [7:0] db);
    bit risen = 0, wrote = 0;
    ns = 0;
    for (int k = 0; k < 2048; k++) begin
      if (k > 0) @(negedge clk);
      if (wr_stb) wr_stb = 1'b0;
      ln[k] = txd; rd[k] = de; dn[k] = de ^ de_low; em[k] = tdr_empty; iq[k] = tx_irq;
      ns = k + 1;
      if (dn[k]) risen = 1;
      if (b2b && !wrote && risen && em[k]) begin wr_data = db; wr_stb = 1'b1; wrote = 1; end
      if (risen && !dn[k]) break;
    end
  endtask

  function automatic int first_rise();
    for (int k = 0; k < ns; k++) if (dn[k]) return k;
    return -1;
  endfunction

  function automatic int first_low(input int from);
    for (int k = from; k < ns; k++) if (ln[k] == 1'b0) return k;
    return -1;
  endfunction

  task automatic check_bits(input int st, input logic [7:0] d);
    int bad = 0, fb = 0, fe = 0, n = nbits();
    for (int i = 0; i < n; i++) begin
      int s = st + i * P + P / 2;
      bit b = (s >= 0 && s < ns) ? ln[s] : 1'b1;
      if (b !== exp_bit(d, i)) begin
        if (bad == 0) begin fb = b; fe = exp_bit(d, i); end
        bad++;
      end
    end
    chk(bad == 0, "R1 frame bits", fb, fe);
    if (par_en) begin
      int s = st + 9 * P + P / 2;
      chk(s < ns && ln[s] == ((^d) ^ par_odd), "R2 parity bit", s < ns ? ln[s] : -1,
          (^d) ^ par_odd);
    end
  endtask

  task automatic run_frame(input logic [7:0] d, input bit do_wr);
    int rise, st, fall, er, ibad;
    if (do_wr) wr(d);
    capture(0, 8'h00);
    if (do_wr) chk(em[0] == 1'b0, "R7 write clears empty", em[0], 0);
    rise = first_rise();
    st = first_low(rise < 0 ? 0 : rise);
    fall = ns - 1;
    chk(rise >= 0 && st >= 0 && st - rise >= P && st - rise <= 2 * P, "R3 lead", st - rise, P);
    check_bits(st, d);
    chk(fall - st == nbits() * P + 1, "R4 tail", fall - st, nbits() * P + 1);
    er = -1;
    for (int k = st + 1; k < ns; k++) if (em[k] && er < 0) er = k;
    chk(er - st == P, "R7 empty sets after start bit", er - st, P);
    ibad = 0;
    for (int k = 0; k < ns; k++) if (iq[k] != em[k]) ibad++;
    chk(ibad == 0, "R8 irq follows empty", ibad, 0);
    chk(rd[st] == !de_low && rd[fall] == de_low, "R6 polarity", rd[st], !de_low);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(txd == 1'b1 && de == 1'b0, "R10 reset idle", {txd, de}, 2);
    chk(tdr_empty == 1'b1, "R7 reset empty", tdr_empty, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(tx_irq == 1'b1, "R8 irq after reset", tx_irq, 1);

    // Sweep every framing/polarity configuration and tick phase.
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      par_en = c[0]; par_odd = c[1]; two_stop = c[2]; de_low = c[3];
      for (int j = 0; j < 4; j++) begin
        logic [7:0] d;
        case (j)
          0: d = 8'h00;
          1: d = 8'hFF;
          2: d = 8'hA5;
          default: d = 8'(c * 37 + 11);
        endcase
        run_frame(d, 1);
        repeat ((c + j) % P) @(negedge clk);
      end
    end

    // R5: back-to-back bytes keep the driver on.
    par_en = 1'b1; par_odd = 1'b0; two_stop = 1'b1; de_low = 1'b0;
    begin
      int rise, st, n;
      wr(8'h3C);
      capture(1, 8'hC3);
      n = nbits();
      rise = first_rise();
      st = first_low(rise);
      chk(ns - 1 - st == 2 * n * P + 1, "R5 continuous enable", ns - 1 - st, 2 * n * P + 1);
      chk(ln[st + n * P] == 1'b0 && ln[st + n * P - 1] == 1'b1, "R5 no gap",
          ln[st + n * P], 0);
      check_bits(st, 8'h3C);
      check_bits(st + n * P, 8'hC3);
    end

    // R9: overwrite while pending.
    par_en = 1'b0; two_stop = 1'b0;
    repeat (3) @(negedge clk);
    wr(8'h11);
    wr(8'h96);
    begin
      int rise, st, bad;
      capture(0, 8'h00);
      rise = first_rise();
      st = first_low(rise);
      check_bits(st, 8'h96);
      chk(ns - 1 - st == nbits() * P + 1, "R9 single frame", ns - 1 - st, nbits() * P + 1);
      bad = 0;
      for (int k = 0; k < 3 * P; k++) begin
        @(negedge clk);
        if (txd != 1'b1 || de != 1'b0) bad++;
      end
      chk(bad == 0, "R9 overwritten byte not sent", bad, 0);
    end

    // R10: disabled transmitter holds a byte and stays idle.
    @(negedge clk); tx_en = 1'b0;
    wr(8'h5A);
    begin
      int bad = 0;
      for (int k = 0; k < 3 * P; k++) begin
        @(negedge clk);
        if (txd != 1'b1 || de != 1'b0 || tdr_empty != 1'b0 || tx_irq != 1'b0) bad++;
      end
      chk(bad == 0, "R10 disabled idle", bad, 0);
    end
    tx_en = 1'b1;
    run_frame(8'h5A, 0);

    // R10: disable in mid frame.
    wr(8'hE7);
    for (int k = 0; k < 40 && txd; k++) @(negedge clk);
    repeat (2 * P) @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1 && de == 1'b0, "R10 abort mid frame", {txd, de}, 2);
    repeat (P) @(negedge clk);
    tx_en = 1'b1;
    begin
      int bad = 0;
      for (int k = 0; k < 3 * P; k++) begin
        @(negedge clk);
        if (txd != 1'b1 || de != 1'b0 || tdr_empty != 1'b1) bad++;
      end
      chk(bad == 0, "R10 nothing resent", bad, 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule